// File: doc/BRIEF.md
# Strided Stream Address Generator

This block sits in a local memory unit of a coarse-grained reconfigurable array. When the accelerator is composed, software loads one iteration domain: a base address, a run length, a copy count and a stride. The domain then stays fixed while the block runs. A start pulse arms the block, and it waits until the tile-transfer synchronizer reports that the tile buffer holds data. The block then walks the domain at one on-chip memory read per cycle. It has no flow control on the compute side.

The walk is nested. The outer copy index c runs from 0 to copy-1 and the inner element index i runs from 0 to length-1. Each read address is base + c*stride + i, taken modulo the address space. Read data comes back from a synchronous RAM one cycle after its address and leaves on a 32-bit stream with a valid flag. When the last address has been issued, the block pulses done and commit together, so the buffer can be refilled. A behavioural synchronous RAM module is supplied for test.

Top module: `stream_agen`

## Requirements
- R1: When rst_ni is low, the block is idle. mem_ren_o, valid_o, busy_o, done_o and commit_o are all low, and the stored configuration is cleared to zero.
- R2: The configuration is captured on a cycle where cfg_load_i is high and the block is idle. A load while busy_o is high has no effect, either on the current run or on later runs.
- R3: The k-th read of a run, counting from k = 0, uses address base + (k / length)*stride + (k mod length), modulo 2^AW. The copy index is the outer loop.
- R4: A run issues exactly length*copy reads, one per cycle, on consecutive cycles with no gap.
- R5: After a start pulse is accepted, no read is issued until tile_ready_i has been sampled high. The first read appears in the cycle after the first clock edge at which tile_ready_i is high and the block is waiting. After that, tile_ready_i is ignored for the rest of the run.
- R6: valid_o is high exactly one cycle after each cycle in which mem_ren_o is high. While valid_o is high, data_o equals mem_rdata_i.
- R7: done_o and commit_o are high together for one cycle, the cycle right after the last read of a run.
- R8: A start pulse while busy_o is high is ignored. After the current run ends, no further reads occur until the next accepted start.
- R9: If the stored length or copy count is zero, an accepted start issues no reads. It raises done_o, with commit_o low, in the next cycle, and the block stays idle.
- R10: busy_o is high from the cycle after a non-empty start is accepted until the last read. It is low in the done cycle, and mem_ren_o is never high while busy_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_base_i | input | AW | Base address of the domain |
| cfg_len_i | input | LW | Elements per copy (inner count) |
| cfg_copy_i | input | LW | Number of copies (outer count) |
| cfg_stride_i | input | AW | Address step between copies |
| cfg_load_i | input | 1 | Capture the configuration (idle only) |
| go_i | input | 1 | Start pulse |
| tile_ready_i | input | 1 | Tile buffer not empty |
| mem_ren_o | output | 1 | Memory read enable |
| mem_addr_o | output | AW | Memory read address |
| mem_rdata_i | input | DW | Read data from synchronous RAM |
| data_o | output | DW | Output stream data |
| valid_o | output | 1 | Output stream valid |
| busy_o | output | 1 | Run armed or in progress |
| done_o | output | 1 | Run finished pulse |
| commit_o | output | 1 | Tile consumed pulse |

## Verification
The main walk is driven from a table of domains, and each domain separates a different ordering fault:
- The worked setting (base 6, length 3, copy 3, stride 5) separates inner from outer indexing.
- A stride of zero repeats a row.
- A stride smaller than the length makes the rows overlap.
- A length of one steps by stride on every read.
- A base near the top of the space checks that the address wraps.

Different ready delays show whether the read waits for the synchronizer and whether the first read lands in the right cycle. Directed cases then cover zero-length and zero-copy starts, a start and a configuration load injected during a run, and a reset in the middle of a run.

// File: rtl/stream_agen_pkg.sv
package stream_agen_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_RUN  = 2'd2
  } agen_state_e;
endpackage

// File: rtl/agen_cfg_regs.sv
module agen_cfg_regs #(
  parameter int AW = 10,
  parameter int LW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic          idle_i,
  input  logic [AW-1:0] base_i,
  input  logic [LW-1:0] len_i,
  input  logic [LW-1:0] copy_i,
  input  logic [AW-1:0] stride_i,
  output logic [AW-1:0] base_o,
  output logic [LW-1:0] len_o,
  output logic [LW-1:0] copy_o,
  output logic [AW-1:0] stride_o,
  output logic          empty_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_o   <= '0;
      len_o    <= '0;
      copy_o   <= '0;
      stride_o <= '0;
    end else if (load_i && idle_i) begin
      base_o   <= base_i;
      len_o    <= len_i;
      copy_o   <= copy_i;
      stride_o <= stride_i;
    end
  end

  assign empty_o = (len_o == '0) || (copy_o == '0);
endmodule

// File: rtl/agen_ctrl.sv
module agen_ctrl
  import stream_agen_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic go_i,
  input  logic ready_i,
  input  logic empty_i,
  input  logic last_i,
  output logic init_o,
  output logic run_o,
  output logic idle_o,
  output logic busy_o,
  output logic done_o,
  output logic commit_o
);
  agen_state_e state_q, state_d;
  logic        done_d, commit_d;

  always_comb begin
    state_d  = state_q;
    done_d   = 1'b0;
    commit_d = 1'b0;
    unique case (state_q)
      ST_IDLE: if (go_i) begin
        if (empty_i) done_d = 1'b1;
        else         state_d = ST_WAIT;
      end
      ST_WAIT: if (ready_i) state_d = ST_RUN;
      ST_RUN: if (last_i) begin
        state_d  = ST_IDLE;
        done_d   = 1'b1;
        commit_d = 1'b1;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      done_o   <= 1'b0;
      commit_o <= 1'b0;
    end else begin
      state_q  <= state_d;
      done_o   <= done_d;
      commit_o <= commit_d;
    end
  end

  assign idle_o = (state_q == ST_IDLE);
  assign run_o  = (state_q == ST_RUN);
  assign busy_o = !idle_o;
  assign init_o = idle_o && go_i && !empty_i;
endmodule

// File: rtl/agen_walker.sv
module agen_walker #(
  parameter int AW = 10,
  parameter int LW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          init_i,
  input  logic          step_i,
  input  logic [AW-1:0] base_i,
  input  logic [LW-1:0] len_i,
  input  logic [LW-1:0] copy_i,
  input  logic [AW-1:0] stride_i,
  output logic [AW-1:0] addr_o,
  output logic          elem_last_o,
  output logic          last_o
);
  logic [LW-1:0] elem_q, cnt_q;
  logic [AW-1:0] row_q;

  assign elem_last_o = (elem_q == len_i - 1'b1);
  assign last_o      = elem_last_o && (cnt_q == copy_i - 1'b1);
  assign addr_o      = row_q + AW'(elem_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      elem_q <= '0;
      cnt_q  <= '0;
      row_q  <= '0;
    end else if (init_i) begin
      elem_q <= '0;
      cnt_q  <= '0;
      row_q  <= base_i;
    end else if (step_i) begin
      if (elem_last_o) begin
        elem_q <= '0;
        cnt_q  <= cnt_q + 1'b1;
        row_q  <= row_q + stride_i;
      end else begin
        elem_q <= elem_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/agen_stream.sv
module agen_stream #(
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ren_i,
  input  logic [DW-1:0] rdata_i,
  output logic [DW-1:0] data_o,
  output logic          valid_o
);
  // RAM is synchronous: data belongs to the read of the previous cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) valid_o <= 1'b0;
    else         valid_o <= ren_i;
  end

  assign data_o = rdata_i;
endmodule

// File: rtl/agen_ram.sv
module agen_ram #(
  parameter int AW = 10,
  parameter int DW = 32,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          re_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem[waddr_i] <= wdata_i;
    if (re_i) rdata_o <= mem[raddr_i];
  end
endmodule

// File: rtl/stream_agen.sv
module stream_agen #(
  parameter int AW = 10,
  parameter int LW = 8,
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] cfg_base_i,
  input  logic [LW-1:0] cfg_len_i,
  input  logic [LW-1:0] cfg_copy_i,
  input  logic [AW-1:0] cfg_stride_i,
  input  logic          cfg_load_i,
  input  logic          go_i,
  input  logic          tile_ready_i,
  output logic          mem_ren_o,
  output logic [AW-1:0] mem_addr_o,
  input  logic [DW-1:0] mem_rdata_i,
  output logic [DW-1:0] data_o,
  output logic          valid_o,
  output logic          busy_o,
  output logic          done_o,
  output logic          commit_o
);
  logic [AW-1:0] base_q, stride_q;
  logic [LW-1:0] len_q, copy_q;
  logic          empty, idle, init, run, last, elem_last;

  agen_cfg_regs #(.AW(AW), .LW(LW)) u_cfg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (cfg_load_i),
    .idle_i   (idle),
    .base_i   (cfg_base_i),
    .len_i    (cfg_len_i),
    .copy_i   (cfg_copy_i),
    .stride_i (cfg_stride_i),
    .base_o   (base_q),
    .len_o    (len_q),
    .copy_o   (copy_q),
    .stride_o (stride_q),
    .empty_o  (empty)
  );

  agen_ctrl u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .go_i     (go_i),
    .ready_i  (tile_ready_i),
    .empty_i  (empty),
    .last_i   (last),
    .init_o   (init),
    .run_o    (run),
    .idle_o   (idle),
    .busy_o   (busy_o),
    .done_o   (done_o),
    .commit_o (commit_o)
  );

  agen_walker #(.AW(AW), .LW(LW)) u_walk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .init_i      (init),
    .step_i      (run),
    .base_i      (base_q),
    .len_i       (len_q),
    .copy_i      (copy_q),
    .stride_i    (stride_q),
    .addr_o      (mem_addr_o),
    .elem_last_o (elem_last),
    .last_o      (last)
  );

  agen_stream #(.DW(DW)) u_out (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .ren_i   (run),
    .rdata_i (mem_rdata_i),
    .data_o  (data_o),
    .valid_o (valid_o)
  );

  assign mem_ren_o = run;
endmodule

// File: rtl/stream_agen_chk.sv
module stream_agen_chk #(
  parameter int AW = 10,
  parameter int LW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          mem_ren_i,
  input logic [AW-1:0] mem_addr_i,
  input logic          valid_i,
  input logic          busy_i,
  input logic          done_i,
  input logic          commit_i,
  input logic          tile_ready_i,
  input logic          elem_last_i,
  input logic [LW-1:0] len_q_i
);
  AST_CFG_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i && $past(busy_i) |-> $stable(len_q_i)); // R2
  AST_ADDR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_ren_i && !elem_last_i |=> mem_ren_i && (mem_addr_i == $past(mem_addr_i) + 1'b1)); // R3
  AST_READ_NEEDS_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_ren_i) |-> $past(tile_ready_i)); // R5
  AST_VALID_LAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i == $past(mem_ren_i)); // R6
  AST_COMMIT_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_i |-> done_i); // R7
  AST_COMMIT_AFTER_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_i |-> $past(mem_ren_i) && !mem_ren_i); // R7
  AST_COMMIT_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_i |=> !commit_i); // R7
  AST_READ_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_ren_i |-> busy_i); // R10
endmodule

bind stream_agen stream_agen_chk #(.AW(AW), .LW(LW)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .mem_ren_i    (mem_ren_o),
  .mem_addr_i   (mem_addr_o),
  .valid_i      (valid_o),
  .busy_i       (busy_o),
  .done_i       (done_o),
  .commit_i     (commit_o),
  .tile_ready_i (tile_ready_i),
  .elem_last_i  (elem_last),
  .len_q_i      (len_q)
);

// File: tb/tb_stream_agen.sv
`timescale 1ns/1ps
module tb_stream_agen;
  localparam int AW = 10;
  localparam int LW = 8;
  localparam int DW = 32;

  typedef struct packed {
    logic [AW-1:0] base;
    logic [LW-1:0] len;
    logic [LW-1:0] copy;
    logic [AW-1:0] stride;
    logic [7:0]    dly;
    logic [AW-1:0] exp_last;
    logic [15:0]   exp_cnt;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{10'd6,    8'd3, 8'd3, 10'd5,  8'd0, 10'd18,  16'd9},
    '{10'd0,    8'd1, 8'd1, 10'd0,  8'd2, 10'd0,   16'd1},
    '{10'd100,  8'd4, 8'd2, 10'd0,  8'd1, 10'd103, 16'd8},
    '{10'd1020, 8'd4, 8'd2, 10'd8,  8'd0, 10'd7,   16'd8},
    '{10'd50,   8'd5, 8'd4, 10'd2,  8'd3, 10'd60,  16'd20},
    '{10'd200,  8'd1, 8'd6, 10'd10, 8'd0, 10'd250, 16'd6}
  };

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [AW-1:0] cfg_base_i = '0, cfg_stride_i = '0;
  logic [LW-1:0] cfg_len_i = '0, cfg_copy_i = '0;
  logic          cfg_load_i = 1'b0, go_i = 1'b0, tile_ready_i = 1'b0;
  logic          mem_ren_o, valid_o, busy_o, done_o, commit_o;
  logic [AW-1:0] mem_addr_o;
  logic [DW-1:0] mem_rdata, data_o;
  logic          we = 1'b0;
  logic [AW-1:0] waddr = '0;
  logic [DW-1:0] wdata = '0;

  int n_chk = 0;
  int n_err = 0;

  always #2.5 clk_i = ~clk_i;

  stream_agen #(.AW(AW), .LW(LW), .DW(DW)) dut (
    .clk_i, .rst_ni, .cfg_base_i, .cfg_len_i, .cfg_copy_i, .cfg_stride_i,
    .cfg_load_i, .go_i, .tile_ready_i, .mem_ren_o, .mem_addr_o,
    .mem_rdata_i(mem_rdata), .data_o, .valid_o, .busy_o, .done_o, .commit_o
  );

  agen_ram #(.AW(AW), .DW(DW)) u_ram (
    .clk_i, .we_i(we), .waddr_i(waddr), .wdata_i(wdata),
    .re_i(mem_ren_o), .raddr_i(mem_addr_o), .rdata_o(mem_rdata)
  );

  function automatic logic [DW-1:0] pat(input logic [AW-1:0] a);
    return 32'hC0DE_0000 | DW'(a);
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  // inj: 0 none, 1 start pulse mid-run, 2 config load mid-run
  task automatic run_vec(input vec_t v, input bit do_load, input int inj);
    int nread = 0, last_ren = -10, first_ren = -1, gaps = 0;
    bit fin = 0, rdy_seen = 0, pend = 0;
    logic [DW-1:0] pend_d = '0;
    logic [AW-1:0] lastaddr = '0;
    if (do_load) begin
      @(negedge clk_i);
      cfg_base_i = v.base; cfg_len_i = v.len; cfg_copy_i = v.copy; cfg_stride_i = v.stride;
      cfg_load_i = 1'b1;
    end
    @(negedge clk_i);
    cfg_load_i = 1'b0;
    go_i = 1'b1;
    tile_ready_i = (v.dly == 0);
    rdy_seen = tile_ready_i;
    for (int cyc = 0; cyc < 1000 && !fin; cyc++) begin
      @(negedge clk_i);
      if (cyc == 0) chk(busy_o == 1'b1, "R10 busy after start", 32'(busy_o), 1);
      if (valid_o) chk(pend && data_o == pend_d, "R6 data/valid", data_o, pend_d);
      else chk(!pend, "R6 valid missing", 32'(valid_o), 32'(pend));
      pend = 1'b0;
      if (mem_ren_o) begin
        automatic logic [AW-1:0] ea = v.base + AW'((nread / v.len) * v.stride) + AW'(nread % v.len);
        if (!rdy_seen) chk(0, "R5 read before ready", 32'(cyc), 0);
        chk(mem_addr_o == ea, "R3 address", 32'(mem_addr_o), 32'(ea));
        if (nread > 0 && last_ren != cyc - 1) gaps++;
        if (first_ren < 0) first_ren = cyc;
        last_ren = cyc;
        lastaddr = mem_addr_o;
        nread++;
        pend = 1'b1;
        pend_d = pat(ea);
      end
      if (done_o) begin
        chk(cyc == last_ren + 1, "R7 done timing", 32'(cyc), 32'(last_ren + 1));
        chk(commit_o == 1'b1, "R7 commit with done", 32'(commit_o), 1);
        chk(busy_o == 1'b0, "R10 busy low at done", 32'(busy_o), 0);
        fin = 1;
      end else if (commit_o) chk(0, "R7 commit without done", 1, 0);
      go_i = (inj == 1 && cyc == 3);
      cfg_load_i = (inj == 2 && cyc == 3);
      if (inj == 2 && cyc == 3) begin
        cfg_base_i = 10'd999; cfg_len_i = 8'd7; cfg_copy_i = 8'd1; cfg_stride_i = 10'd3;
      end
      if (cyc + 1 >= int'(v.dly)) tile_ready_i = 1'b1;
      rdy_seen |= tile_ready_i;
    end
    go_i = 1'b0; cfg_load_i = 1'b0; tile_ready_i = 1'b0;
    chk(fin, "R7 done seen", 32'(fin), 1);
    chk(nread == int'(v.exp_cnt), "R4 read count", 32'(nread), 32'(v.exp_cnt));
    chk(gaps == 0, "R4 contiguous reads", 32'(gaps), 0);
    chk(lastaddr == v.exp_last, "R3 last address", 32'(lastaddr), 32'(v.exp_last));
    chk(first_ren == ((v.dly == 0) ? 1 : int'(v.dly)), "R5 first read cycle",
        32'(first_ren), (v.dly == 0) ? 1 : 32'(v.dly));
    @(negedge clk_i);
    chk(valid_o == 1'b0, "R6 valid drops", 32'(valid_o), 0);
  endtask

  initial begin
    for (int c = 0; c < 150000; c++) @(posedge clk_i);
    n_err++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    // R1: reset state
    #1;
    chk(!mem_ren_o && !valid_o && !busy_o && !done_o && !commit_o, "R1 reset outputs",
        {mem_ren_o, valid_o, busy_o, done_o, commit_o}, 0);
    for (int a = 0; a < (1 << AW); a++) begin
      @(negedge clk_i); we = 1'b1; waddr = AW'(a); wdata = pat(AW'(a));
    end
    @(negedge clk_i); we = 1'b0;
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(!busy_o && !mem_ren_o, "R1 idle after reset", {busy_o, mem_ren_o}, 0);

    // table walk: R3 R4 R5 R6 R7 R10
    for (int k = 0; k < NV; k++) run_vec(VECS[k], 1'b1, 0);

    // R8: start while busy ignored
    run_vec(VECS[4], 1'b1, 1);
    begin
      int extra = 0;
      for (int c = 0; c < 8; c++) begin
        @(negedge clk_i);
        if (mem_ren_o || busy_o) extra++;
      end
      chk(extra == 0, "R8 no restart after mid-run start", 32'(extra), 0);
    end

    // R2: load while busy ignored, now and for the next run
    run_vec(VECS[0], 1'b1, 2);
    run_vec(VECS[0], 1'b0, 0);

    // R9: zero length and zero copy
    for (int z = 0; z < 2; z++) begin
      @(negedge clk_i);
      cfg_base_i = 10'd40; cfg_stride_i = 10'd4;
      cfg_len_i = (z == 0) ? 8'd0 : 8'd5;
      cfg_copy_i = (z == 0) ? 8'd3 : 8'd0;
      cfg_load_i = 1'b1;
      @(negedge clk_i); cfg_load_i = 1'b0; go_i = 1'b1; tile_ready_i = 1'b1;
      @(negedge clk_i); go_i = 1'b0;
      chk(done_o && !commit_o && !mem_ren_o && !busy_o, "R9 empty domain done",
          {done_o, commit_o, mem_ren_o, busy_o}, 4'b1000);
      @(negedge clk_i);
      chk(!done_o && !mem_ren_o && !busy_o, "R9 empty domain stays idle",
          {done_o, mem_ren_o, busy_o}, 0);
      tile_ready_i = 1'b0;
    end

    // R1: reset mid-run
    @(negedge clk_i);
    cfg_base_i = 10'd10; cfg_len_i = 8'd8; cfg_copy_i = 8'd8; cfg_stride_i = 10'd16;
    cfg_load_i = 1'b1;
    @(negedge clk_i); cfg_load_i = 1'b0; go_i = 1'b1; tile_ready_i = 1'b1;
    @(negedge clk_i); go_i = 1'b0;
    repeat (4) @(negedge clk_i);
    chk(mem_ren_o, "R1 run active before reset", 32'(mem_ren_o), 1);
    rst_ni = 1'b0;
    #1;
    chk(!mem_ren_o && !valid_o && !busy_o && !done_o && !commit_o, "R1 reset mid-run",
        {mem_ren_o, valid_o, busy_o, done_o, commit_o}, 0);
    @(negedge clk_i); rst_ni = 1'b1; tile_ready_i = 1'b0;
    // R1: config cleared, so a bare start is an empty domain
    go_i = 1'b1;
    @(negedge clk_i); go_i = 1'b0;
    chk(done_o && !busy_o, "R1 config cleared by reset", {done_o, busy_o}, 2'b10);
    repeat (2) @(negedge clk_i);
    summary();
  end
endmodule